// File: doc/BRIEF.md
# Mixed-width true dual-port RAM

This block is a synchronous memory with two fully independent ports, A and B. Each port has its own clock, enable, write enable, synchronous output reset and address. Both ports reach one shared store of 16384 data bits and 2048 parity bits. Each port's width is a parameter, chosen separately from 1, 2, 4, 9, 18 or 36 bits. A word written through a port of one width can therefore be read back through the other port at a different width, so the block also converts between bus widths.

The 9-, 18- and 36-bit widths carry one parity bit for every data byte, on a separate parity bus. The memory only stores those bits and never computes or checks them. The 1-, 2- and 4-bit widths see only the data bits. For each port, parameters select the active clock edge and the active level of enable, write enable and reset. A write on one port and an access to the same bits on the other port at a coinciding edge give undefined results, and users must avoid them.

Top module: `tdp_ram`

## Requirements
- R1: A port of width 9, 18 or 36 carries 8, 16 or 32 data bits plus 1, 2 or 4 parity bits. A port of width 1, 2 or 4 carries only that many data bits. The address width is log2(16384 / data bits).
- R2: Data word a of a port with d data bits occupies shared data bits a*d to a*d+d-1, least significant bit first. A word written by one port reads back on the other port at the matching address and lane.
- R3: Parity bit k at address a of a port with p parity bits is shared parity bit a*p+k. A port of width 1, 2 or 4 never changes parity, and its parity output reads 0.
- R4: A read with enable active and write and reset inactive presents the addressed word on the outputs after the active edge that sampled the address.
- R5: A write with enable active stores the word and also drives it onto that port's data and parity outputs after the same edge.
- R6: While enable is inactive the port ignores write and reset, and its outputs hold their value.
- R7: Reset with enable active loads the outputs with the port's INIT parameter (data in the low bits, parity above them) and leaves memory unchanged. A write in the same cycle is still stored.
- R8: With the CLK_INV parameter at 1 the port acts on the falling clock edge, and its outputs stay stable across the rising edge. With CLK_INV at 0 the port acts on the rising edge.
- R9: Each of EN_INV, WE_INV and RST_INV set to 1 makes the matching input active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_rst | input | 1 | Port A synchronous output reset |
| a_addr | input | A_AW | Port A word address |
| a_din | input | A_DW | Port A write data |
| a_pin | input | A_PB | Port A write parity (unused below width 9) |
| a_dout | output | A_DW | Port A read data |
| a_pout | output | A_PB | Port A read parity (0 below width 9) |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_rst | input | 1 | Port B synchronous output reset |
| b_addr | input | B_AW | Port B word address |
| b_din | input | B_DW | Port B write data |
| b_pin | input | B_PB | Port B write parity (unused below width 9) |
| b_dout | output | B_DW | Port B read data |
| b_pout | output | B_PB | Port B read parity (0 below width 9) |

## Verification
An output reset and a write can arrive in the same enabled cycle. The outputs must then show INIT while the array still takes the new word. The bench sets reset and write at random and independently on every port, so the two often coincide. Its reference model writes its own store and places INIT on its expected output. Every later read, on either port and at any width, then shows whether the word was stored, and the next edge shows whether the output reset won.

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int          A_WIDTH   = 36,
  parameter int          B_WIDTH   = 9,
  parameter bit          A_CLK_INV = 1'b0,
  parameter bit          A_EN_INV  = 1'b0,
  parameter bit          A_WE_INV  = 1'b0,
  parameter bit          A_RST_INV = 1'b0,
  parameter logic [35:0] A_INIT    = '0,
  parameter bit          B_CLK_INV = 1'b0,
  parameter bit          B_EN_INV  = 1'b0,
  parameter bit          B_WE_INV  = 1'b0,
  parameter bit          B_RST_INV = 1'b0,
  parameter logic [35:0] B_INIT    = '0,
  localparam int A_DW = (A_WIDTH >= 9) ? (A_WIDTH / 9) * 8 : A_WIDTH,
  localparam int A_PW = A_WIDTH - A_DW,
  localparam int A_PB = (A_PW > 0) ? A_PW : 1,
  localparam int A_AW = $clog2(16384 / A_DW),
  localparam int B_DW = (B_WIDTH >= 9) ? (B_WIDTH / 9) * 8 : B_WIDTH,
  localparam int B_PW = B_WIDTH - B_DW,
  localparam int B_PB = (B_PW > 0) ? B_PW : 1,
  localparam int B_AW = $clog2(16384 / B_DW)
) (
  input  logic            a_clk,
  input  logic            a_en,
  input  logic            a_we,
  input  logic            a_rst,
  input  logic [A_AW-1:0] a_addr,
  input  logic [A_DW-1:0] a_din,
  input  logic [A_PB-1:0] a_pin,
  output logic [A_DW-1:0] a_dout,
  output logic [A_PB-1:0] a_pout,
  input  logic            b_clk,
  input  logic            b_en,
  input  logic            b_we,
  input  logic            b_rst,
  input  logic [B_AW-1:0] b_addr,
  input  logic [B_DW-1:0] b_din,
  input  logic [B_PB-1:0] b_pin,
  output logic [B_DW-1:0] b_dout,
  output logic [B_PB-1:0] b_pout
);
  localparam int ROWS  = 512;
  localparam int A_LPR = 32 / A_DW;
  localparam int B_LPR = 32 / B_DW;

  // each port owns one bank; the stored value is the XOR of both banks
  logic [35:0] bank_a [ROWS];
  logic [35:0] bank_b [ROWS];

  logic ka, ena, wea, rsta, kb, enb, web, rstb;
  assign ka   = a_clk ^ A_CLK_INV;
  assign ena  = a_en  ^ A_EN_INV;
  assign wea  = a_we  ^ A_WE_INV;
  assign rsta = a_rst ^ A_RST_INV;
  assign kb   = b_clk ^ B_CLK_INV;
  assign enb  = b_en  ^ B_EN_INV;
  assign web  = b_we  ^ B_WE_INV;
  assign rstb = b_rst ^ B_RST_INV;

  logic [8:0]  row_a, row_b;
  logic [4:0]  lane_a, lane_b, doff_a, doff_b;
  logic [1:0]  poff_a, poff_b;
  logic [35:0] cur_a, cur_b, wmask_a, wdat_a, wmask_b, wdat_b;

  assign row_a  = 9'(a_addr / A_LPR);
  assign lane_a = 5'(a_addr % A_LPR);
  assign doff_a = 5'(lane_a * A_DW);
  assign poff_a = 2'(lane_a * A_PW);
  assign row_b  = 9'(b_addr / B_LPR);
  assign lane_b = 5'(b_addr % B_LPR);
  assign doff_b = 5'(lane_b * B_DW);
  assign poff_b = 2'(lane_b * B_PW);

  assign cur_a = bank_a[row_a] ^ bank_b[row_a];
  assign cur_b = bank_a[row_b] ^ bank_b[row_b];

  always_comb begin
    wmask_a = '0;
    wdat_a  = '0;
    wmask_a[doff_a +: A_DW] = '1;
    wdat_a[doff_a +: A_DW]  = a_din;
    if (A_PW > 0) begin
      wmask_a[32 + poff_a +: A_PB] = '1;
      wdat_a[32 + poff_a +: A_PB]  = a_pin;
    end
  end

  always_comb begin
    wmask_b = '0;
    wdat_b  = '0;
    wmask_b[doff_b +: B_DW] = '1;
    wdat_b[doff_b +: B_DW]  = b_din;
    if (B_PW > 0) begin
      wmask_b[32 + poff_b +: B_PB] = '1;
      wdat_b[32 + poff_b +: B_PB]  = b_pin;
    end
  end

  always_ff @(posedge ka) begin
    if (ena) begin
      if (wea)
        bank_a[row_a] <= (bank_a[row_a] & ~wmask_a) | ((wdat_a ^ bank_b[row_a]) & wmask_a);
      a_dout <= rsta ? A_INIT[A_DW-1:0] : wea ? a_din : cur_a[doff_a +: A_DW];
      a_pout <= (A_PW == 0) ? '0 : rsta ? A_INIT[A_DW +: A_PB] :
                wea ? a_pin : cur_a[32 + poff_a +: A_PB];
    end
  end

  always_ff @(posedge kb) begin
    if (enb) begin
      if (web)
        bank_b[row_b] <= (bank_b[row_b] & ~wmask_b) | ((wdat_b ^ bank_a[row_b]) & wmask_b);
      b_dout <= rstb ? B_INIT[B_DW-1:0] : web ? b_din : cur_b[doff_b +: B_DW];
      b_pout <= (B_PW == 0) ? '0 : rstb ? B_INIT[B_DW +: B_PB] :
                web ? b_pin : cur_b[32 + poff_b +: B_PB];
    end
  end

  logic a_live = 1'b0;
  logic b_live = 1'b0;
  always_ff @(posedge ka) a_live <= 1'b1;
  always_ff @(posedge kb) b_live <= 1'b1;

  AST_A_HOLD: assert property (@(posedge ka) disable iff (!a_live)
    !ena |=> $stable(a_dout) && $stable(a_pout)) else $error("port A output moved while disabled"); // R6
  AST_A_RESET: assert property (@(posedge ka) disable iff (!a_live)
    ena && rsta |=> a_dout == A_INIT[A_DW-1:0]) else $error("port A reset value wrong"); // R7
  AST_A_WRITE_FIRST: assert property (@(posedge ka) disable iff (!a_live)
    ena && wea && !rsta |=> a_dout == $past(a_din)) else $error("port A write-first wrong"); // R5
  AST_B_HOLD: assert property (@(posedge kb) disable iff (!b_live)
    !enb |=> $stable(b_dout) && $stable(b_pout)) else $error("port B output moved while disabled"); // R6
  AST_B_RESET: assert property (@(posedge kb) disable iff (!b_live)
    enb && rstb |=> b_dout == B_INIT[B_DW-1:0]) else $error("port B reset value wrong"); // R7
  AST_B_WRITE_FIRST: assert property (@(posedge kb) disable iff (!b_live)
    enb && web && !rstb |=> b_dout == $past(b_din)) else $error("port B write-first wrong"); // R5
endmodule

// File: tb/tdp_ram_test.sv
module tdp_ram_test;
  localparam int PERIOD = 10;
  localparam int FILL   = 2048;
  localparam int RANDOM = 4000;

  // slots: 0 = uut A (36), 1 = uut B (9), 2 = uut2 A (4), 3 = uut2 B (18)
  localparam int          WID   [4] = '{36, 9, 4, 18};
  localparam logic [35:0] INITV [4] = '{36'h987654321, 36'h1A5, 36'hC, 36'h2BEEF};

  logic clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  bit          s_en [4];
  bit          s_we [4];
  bit          s_rst[4];
  int          s_addr[4];
  logic [31:0] s_din[4];
  logic [3:0]  s_pin[4];

  logic [31:0] u0_ad; logic [3:0] u0_ap;
  logic [7:0]  u0_bd; logic [0:0] u0_bp;
  logic [3:0]  u1_ad; logic [0:0] u1_ap;
  logic [15:0] u1_bd; logic [1:0] u1_bp;

  // uut: A 36-bit rising, active high; B 9-bit falling (R8), active-low enable and reset (R9)
  tdp_ram #(.A_WIDTH(36), .B_WIDTH(9), .A_INIT(36'h987654321),
            .B_CLK_INV(1'b1), .B_EN_INV(1'b1), .B_RST_INV(1'b1), .B_INIT(36'h1A5)) uut (
    .a_clk(clk), .a_en(s_en[0]), .a_we(s_we[0]), .a_rst(s_rst[0]),
    .a_addr(9'(s_addr[0])), .a_din(s_din[0]), .a_pin(s_pin[0]),
    .a_dout(u0_ad), .a_pout(u0_ap),
    .b_clk(clk), .b_en(~s_en[1]), .b_we(s_we[1]), .b_rst(~s_rst[1]),
    .b_addr(11'(s_addr[1])), .b_din(s_din[1][7:0]), .b_pin(s_pin[1][0]),
    .b_dout(u0_bd), .b_pout(u0_bp));

  // uut2: A 4-bit rising, active-low write (R9); B 18-bit falling
  tdp_ram #(.A_WIDTH(4), .B_WIDTH(18), .A_WE_INV(1'b1), .A_INIT(36'hC),
            .B_CLK_INV(1'b1), .B_INIT(36'h2BEEF)) uut2 (
    .a_clk(clk), .a_en(s_en[2]), .a_we(~s_we[2]), .a_rst(s_rst[2]),
    .a_addr(12'(s_addr[2])), .a_din(s_din[2][3:0]), .a_pin(s_pin[2][0]),
    .a_dout(u1_ad), .a_pout(u1_ap),
    .b_clk(clk), .b_en(s_en[3]), .b_we(s_we[3]), .b_rst(s_rst[3]),
    .b_addr(10'(s_addr[3])), .b_din(s_din[3][15:0]), .b_pin(s_pin[3][1:0]),
    .b_dout(u1_bd), .b_pout(u1_bp));

  bit [16383:0] ref_d[2];
  bit [2047:0]  ref_p[2];
  logic [31:0]  exp_d[4];
  logic [3:0]   exp_p[4];
  bit           known[4];
  int checks = 0;
  int fails  = 0;

  function automatic int dbits(int w); return (w >= 9) ? (w / 9) * 8 : w; endfunction
  function automatic int pbits(int w); return w - dbits(w); endfunction

  function automatic logic [31:0] got_d(int s);
    case (s)
      0: return u0_ad;
      1: return 32'(u0_bd);
      2: return 32'(u1_ad);
      default: return 32'(u1_bd);
    endcase
  endfunction

  function automatic logic [3:0] got_p(int s);
    case (s)
      0: return u0_ap;
      1: return 4'(u0_bp);
      2: return 4'(u1_ap);
      default: return 4'(u1_bp);
    endcase
  endfunction

  task automatic compare(int s, string tag);
    checks++;
    if (got_d(s) !== exp_d[s] || got_p(s) !== exp_p[s]) begin
      fails++;
      $display("FAIL %s slot %0d: actual d=%h p=%h expected d=%h p=%h",
               tag, s, got_d(s), got_p(s), exp_d[s], exp_p[s]);
    end
  endtask

  // model one active edge of slot s, then compare
  task automatic step(int s);
    int k = s / 2;
    int d = dbits(WID[s]);
    int p = pbits(WID[s]);
    logic [31:0] dm = (d == 32) ? 32'hFFFF_FFFF : (32'd1 << d) - 1;
    logic [3:0]  pm = 4'((1 << p) - 1);
    string tag;
    if (!s_en[s]) tag = "R6 R9 hold";
    else begin
      known[s] = 1'b1;
      if (s_rst[s]) begin
        exp_d[s] = INITV[s][31:0] & dm;
        exp_p[s] = 4'(INITV[s] >> d) & pm;
        tag = "R7 reset";
      end else if (s_we[s]) begin
        exp_d[s] = s_din[s] & dm;
        exp_p[s] = s_pin[s] & pm;
        tag = "R5 write-first";
      end else begin
        for (int i = 0; i < 32; i++) exp_d[s][i] = (i < d) ? ref_d[k][s_addr[s] * d + i] : 1'b0;
        for (int j = 0; j < 4; j++)  exp_p[s][j] = (j < p) ? ref_p[k][s_addr[s] * p + j] : 1'b0;
        tag = (p > 0) ? "R1 R2 R3 R4 read" : "R1 R2 R3 R4 narrow read";
      end
      if (s_we[s]) begin
        for (int i = 0; i < d; i++) ref_d[k][s_addr[s] * d + i] = s_din[s][i];
        for (int j = 0; j < p; j++) ref_p[k][s_addr[s] * p + j] = s_pin[s][j];
      end
    end
    if (known[s]) compare(s, tag);
  endtask

  task automatic stable(int s);
    if (known[s]) compare(s, "R8 off-edge stable");
  endtask

  // mode 0: reset all; 1: fill through B ports, cycle n; 2: random
  task automatic gen(int s, int mode, int n);
    int d = dbits(WID[s]);
    s_din[s] = $urandom;
    s_pin[s] = 4'($urandom);
    if (mode == 0) begin
      s_en[s] = 1'b1; s_rst[s] = 1'b1; s_we[s] = 1'b0; s_addr[s] = 0;
    end else if (mode == 1) begin
      s_en[s]   = (s == 1) || (s == 3 && n < 1024);
      s_we[s]   = 1'b1;
      s_rst[s]  = (n % 97) == 5;
      s_addr[s] = (s == 3) ? n % 1024 : n;
    end else begin
      s_en[s]   = ($urandom_range(0, 9) < 8);
      s_we[s]   = ($urandom_range(0, 9) < 4);
      s_rst[s]  = ($urandom_range(0, 9) < 1);
      s_addr[s] = $urandom_range(0, 16384 / d - 1);
      if ($urandom_range(0, 3) == 0) s_addr[s] = s_addr[s] % 8;
    end
  endtask

  task automatic run_cycle(int mode, int n);
    @(posedge clk); #1;
    step(0); step(2); stable(1); stable(3);
    gen(1, mode, n); gen(3, mode, n);
    @(negedge clk); #1;
    step(1); step(3); stable(0); stable(2);
    gen(0, (mode == 1) ? 1 : mode, n); gen(2, (mode == 1) ? 1 : mode, n);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) gen(s, 0, 0);
    run_cycle(0, 0);
    for (int n = 0; n < FILL; n++) run_cycle(1, n);
    for (int n = 0; n < RANDOM; n++) run_cycle(2, n);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule